// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Level Resolution

This block is one port of sixteen general-purpose pins, configured through a small 32-bit memory-mapped register bus. Each pin has a direction code, a driver style (push-pull or open-drain), a pull selection and an output data bit. The output data bits can be set or cleared atomically. Every cycle each pin's level is resolved from its configuration, its output latch and the last level an outside agent drove onto it. Whether that outside driver still reaches the pin is also part of the resolution.

The resolved levels are registered. They can be read back as an input data word, and they also leave the block as sixteen level lines toward a system configuration or interrupt controller. An outside driver reports a change by pulsing `ext_evt` for a pin with the new level on `ext_lvl`. The output driver can cut an outside driver off, and the outside driver stays cut off until it drives the pin again. All reset values, including the level a floating unpulled pin settles to, are parameters.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, pull, driver-style and output registers read their parameter values (defaults: direction 0xFFFFFEBF, pull 0x00000100, style 0, output 0). Reads of the set/clear word (offset 0x18), the clear-only word (offset 0x28) and any unmapped offset return 0. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R2: The direction register holds 2 bits per pin at bit 2*pin. Code 1 makes the pin an output. Codes 0, 2 and 3 make it an input. Offset 0x00.
- R3: A write to the set/clear word (offset 0x18) sets output bit i for each written bit i in 15:0 and clears output bit i for each written bit 16+i. When both bits for a pin are 1, the pin ends up set. The output register itself is at offset 0x14.
- R4: A write to the clear-only word (offset 0x28) clears every output bit whose written bit in 15:0 is 1 and leaves the other bits unchanged.
- R5: An output bit written while its pin is an input is stored and reads back. It does not change the pin level until the pin becomes an output.
- R6: An input pin whose outside driver is connected reads the driven level. An input pin with no connected driver reads 1 with pull code 1 and 0 with pull code 2. The pull register uses 2 bits per pin at offset 0x0C.
- R7: A floating input pin with pull code 0 or 3 reads its parameterised idle level (default: pin 5 high, the rest low).
- R8: A push-pull output pin (style bit 0 at offset 0x04) reads its output bit. Outside drives of either level are ignored, and the driver stays disconnected after the pin goes back to input.
- R9: On an open-drain output pin (style bit 1), an outside high is disconnected and ignored. A connected outside low forces the pin to 0 even when its output bit is 1.
- R10: An outside drive event reconnects the pin unless it is blocked. A drive is blocked on a push-pull output, and a high drive is blocked on an open-drain output.
- R11: The input data word (offset 0x10) is read-only; writes to it change no register and no pin. It and `pin_lvl` show the resolved levels one cycle after the state they derive from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ext_evt | input | 16 | Per-pin pulse: an outside agent drives the pin |
| ext_lvl | input | 16 | Level driven by the outside agent, sampled with `ext_evt` |
| pin_lvl | output | 16 | Registered resolved level of each pin |

## Verification
The bench goes after the set-wins case of the set/clear word. A design that gave clear the priority would drop the bit. It checks that a pin driven high while it was a push-pull output reads its idle level once it returns to input. A design that never cut the driver would keep showing 1 there. On an open-drain pin it checks that a connected outside low beats an output bit of 1, and that a later low drive reconnects a pin that a high drive had cut. Getting either of these wrong shows up as a stuck or inverted level. It also checks that direction codes 2 and 3 behave as input and that writes to the input word leave every register untouched.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STYLE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PULL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SETCLR = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLRONLY = 8'h28;

  typedef enum logic [1:0] {
    DIR_IN  = 2'd0,
    DIR_OUT = 2'd1,
    DIR_X2  = 2'd2,
    DIR_X3  = 2'd3
  } dir_code_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_UP   = 2'd1,
    PULL_DOWN = 2'd2,
    PULL_RSV  = 2'd3
  } pull_code_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS     = 16,
  parameter logic [2*NPINS-1:0] RST_DIR   = '1,
  parameter logic [2*NPINS-1:0] RST_PULL  = '0,
  parameter logic [NPINS-1:0]   RST_STYLE = '0,
  parameter logic [NPINS-1:0]   RST_OUT   = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [2*NPINS-1:0]   bus_wdata,
  output logic [2*NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]     lvl,
  output logic [2*NPINS-1:0]   dir_q,
  output logic [2*NPINS-1:0]   pull_q,
  output logic [NPINS-1:0]     style_q,
  output logic [NPINS-1:0]     out_q
);
  localparam int unsigned DW = 2*NPINS;

  logic [NPINS-1:0] set_bits, clr_bits;
  assign set_bits = bus_wdata[NPINS-1:0];
  assign clr_bits = bus_wdata[DW-1:NPINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= RST_DIR;
      pull_q  <= RST_PULL;
      style_q <= RST_STYLE;
      out_q   <= RST_OUT;
    end else if (bus_wr) begin
      unique case (bus_addr)
        OFS_DIR:     dir_q   <= bus_wdata;
        OFS_PULL:    pull_q  <= bus_wdata;
        OFS_STYLE:   style_q <= bus_wdata[NPINS-1:0];
        OFS_OUT:     out_q   <= bus_wdata[NPINS-1:0];
        OFS_SETCLR:  out_q   <= (out_q & ~clr_bits) | set_bits;
        OFS_CLRONLY: out_q   <= out_q & ~set_bits;
        default: ;
      endcase
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      OFS_DIR:   rd_mux = dir_q;
      OFS_PULL:  rd_mux = pull_q;
      OFS_STYLE: rd_mux = {{NPINS{1'b0}}, style_q};
      OFS_OUT:   rd_mux = {{NPINS{1'b0}}, out_q};
      OFS_LEVEL: rd_mux = {{NPINS{1'b0}}, lvl};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_SETCLR) |=>
      ((out_q & $past(set_bits)) == $past(set_bits)));

  p_clear_only_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CLRONLY) |=>
      ((out_q & $past(set_bits)) == '0 &&
       (out_q & ~$past(set_bits)) == ($past(out_q) & ~$past(set_bits))));

  p_level_ro_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_LEVEL) |=>
      ($stable(dir_q) && $stable(pull_q) && $stable(style_q) && $stable(out_q)));

  p_strobe_reads_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == OFS_SETCLR || bus_addr == OFS_CLRONLY)) |=>
      (bus_rdata == '0));
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] dir,
  input  logic [1:0] pull,
  input  logic       open_drain,
  input  logic       out_bit,
  input  logic       evt,
  input  logic       evt_lvl,
  output logic       lvl_q
);
  logic is_out, conn_q, drv_q, blocked, lvl_d;

  assign is_out = (dir_code_e'(dir) == DIR_OUT);
  // an outside drive cannot reach a push-pull output, nor raise an open-drain one
  assign blocked = is_out && (!open_drain || evt_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      drv_q  <= 1'b0;
    end else if (evt) begin
      conn_q <= !blocked;
      drv_q  <= evt_lvl;
    end else if (is_out && (!open_drain || drv_q)) begin
      conn_q <= 1'b0;
    end
  end

  always_comb begin
    if (is_out) begin
      if (!open_drain) lvl_d = out_bit;
      else             lvl_d = out_bit & (!conn_q | drv_q);
    end else if (conn_q) begin
      lvl_d = drv_q;
    end else begin
      unique case (pull_code_e'(pull))
        PULL_UP:   lvl_d = 1'b1;
        PULL_DOWN: lvl_d = 1'b0;
        default:   lvl_d = IDLE_LVL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_d;
  end

  p_push_pull_cuts_r8: assert property (@(posedge clk) disable iff (rst)
    (is_out && !open_drain && !evt) |=> !conn_q);

  p_od_low_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (is_out && open_drain && conn_q && !drv_q) |=> !lvl_q);

  p_input_reconnects_r10: assert property (@(posedge clk) disable iff (rst)
    (evt && !is_out) |=> conn_q);

  p_input_follows_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (!is_out && conn_q) |=> (lvl_q == $past(drv_q)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter logic [2*NPINS-1:0] RST_DIR   = 32'hFFFF_FEBF,
  parameter logic [2*NPINS-1:0] RST_PULL  = 32'h0000_0100,
  parameter logic [NPINS-1:0]   RST_STYLE = 16'h0000,
  parameter logic [NPINS-1:0]   RST_OUT   = 16'h0000,
  parameter logic [NPINS-1:0]   RST_IDLE  = 16'h0020
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [15:0]      ext_evt,
  input  logic [15:0]      ext_lvl,
  output logic [15:0]      pin_lvl
);
  localparam int unsigned DW = 2*NPINS;

  logic [DW-1:0]    dir_q, pull_q;
  logic [NPINS-1:0] style_q, out_q, lvl;

  gpio_cfg_regs #(
    .NPINS(NPINS), .RST_DIR(RST_DIR), .RST_PULL(RST_PULL),
    .RST_STYLE(RST_STYLE), .RST_OUT(RST_OUT)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl(lvl),
    .dir_q(dir_q), .pull_q(pull_q), .style_q(style_q), .out_q(out_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_cell #(.IDLE_LVL(RST_IDLE[i])) u_cell (
      .clk(clk), .rst(rst),
      .dir(dir_q[2*i +: 2]),
      .pull(pull_q[2*i +: 2]),
      .open_drain(style_q[i]),
      .out_bit(out_q[i]),
      .evt(ext_evt[i]),
      .evt_lvl(ext_lvl[i]),
      .lvl_q(lvl[i])
    );
  end

  assign pin_lvl = lvl;
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ext_evt = '0, ext_lvl = '0;
  logic [15:0] pin_lvl;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  logic rd_pend = 1'b0;

  always #4 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_evt(ext_evt), .ext_lvl(ext_lvl), .pin_lvl(pin_lvl)
  );

  // monitor: a read issued before an edge has its data after that edge
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    settle();
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drive(input int pin, input logic v);
    @(negedge clk);
    ext_evt = 16'(1) << pin; ext_lvl[pin] = v;
    @(negedge clk);
    ext_evt = '0;
    settle();
  endtask

  task automatic lvl_chk(input logic [15:0] e, input string tag);
    @(negedge clk);
    checks++;
    if (pin_lvl !== e) begin
      errors++;
      $display("FAIL %s: pin_lvl got %h expected %h", tag, pin_lvl, e);
    end
  endtask

  task automatic both_chk(input logic [15:0] e, input string tag);
    lvl_chk(e, tag);
    rd(8'h10, {16'h0, e}, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset values, strobe words and unmapped offsets
    rd(8'h00, 32'hFFFF_FEBF, "R1 dir reset");
    rd(8'h0C, 32'h0000_0100, "R1 pull reset");
    rd(8'h04, 32'h0, "R1 style reset");
    rd(8'h14, 32'h0, "R1 out reset");
    rd(8'h18, 32'h0, "R1 setclr reads 0");
    rd(8'h28, 32'h0, "R1 clronly reads 0");
    rd(8'h3C, 32'h0, "R1 unmapped reads 0");
    // R6 pull-up on pin4, R7 idle high on pin5
    both_chk(16'h0030, "R7 reset levels");

    // R5 stored while input
    wr(8'h14, 32'h0000_0004);
    rd(8'h14, 32'h0000_0004, "R5 out stored");
    both_chk(16'h0030, "R5 no effect in input");
    // R2 code 1 output, code 2 input
    wr(8'h00, 32'hFFFF_FE9F);
    both_chk(16'h0034, "R2 code1 output");
    wr(8'h00, 32'hFFFF_FEAF);
    both_chk(16'h0030, "R2 code2 input");

    // R3 set/clear, R4 clear-only
    wr(8'h18, 32'h0000_0009);
    rd(8'h14, 32'h0000_000D, "R3 set bits");
    wr(8'h18, 32'h0008_0000);
    rd(8'h14, 32'h0000_0005, "R3 clear bit");
    wr(8'h18, 32'h0002_0002);
    rd(8'h14, 32'h0000_0007, "R3 set wins");
    wr(8'h28, 32'hFFFF_0003);
    rd(8'h14, 32'h0000_0004, "R4 clear only");

    // R6 input follows drive, pulls on floating pins
    drive(6, 1'b1);
    both_chk(16'h0070, "R6 drive high");
    drive(6, 1'b0);
    both_chk(16'h0030, "R6 drive low");
    wr(8'h0C, 32'h0000_4100);
    both_chk(16'h00B0, "R6 pull-up");
    wr(8'h0C, 32'h0000_4900);
    both_chk(16'h0090, "R6 pull-down beats idle");
    wr(8'h0C, 32'h0000_0100);
    both_chk(16'h0030, "R7 idle restored");

    // R8 push-pull on pin8
    drive(8, 1'b1);
    both_chk(16'h0130, "R6 pin8 driven");
    wr(8'h00, 32'hFFFD_FEAF);
    both_chk(16'h0030, "R8 pp reads out bit");
    drive(8, 1'b1);
    both_chk(16'h0030, "R8 high ignored");
    wr(8'h18, 32'h0000_0100);
    both_chk(16'h0130, "R8 follows out bit");
    drive(8, 1'b0);
    both_chk(16'h0130, "R8 low ignored");
    drive(8, 1'b1);
    wr(8'h00, 32'hFFFF_FEAF);
    both_chk(16'h0030, "R8 stays cut in input");
    drive(8, 1'b1);
    both_chk(16'h0130, "R10 reconnect input");
    drive(8, 1'b0);
    both_chk(16'h0030, "R10 follow low");

    // R9 open-drain on pin9
    wr(8'h04, 32'h0000_0200);
    wr(8'h18, 32'h0000_0200);
    drive(9, 1'b0);
    wr(8'h00, 32'hFFF7_FEAF);
    both_chk(16'h0030, "R9 outside low wins");
    drive(9, 1'b1);
    both_chk(16'h0230, "R9 high cut");
    drive(9, 1'b0);
    both_chk(16'h0030, "R10 od low reconnects");
    drive(9, 1'b1);
    wr(8'h28, 32'h0000_0200);
    both_chk(16'h0030, "R9 od out 0");
    wr(8'h18, 32'h0000_0200);
    both_chk(16'h0230, "R9 od out 1");
    // pin10: high drive before open-drain output is cut
    drive(10, 1'b1);
    both_chk(16'h0630, "R6 pin10 driven");
    wr(8'h04, 32'h0000_0600);
    wr(8'h00, 32'hFFD7_FEAF);
    both_chk(16'h0230, "R9 high cut on entry");
    wr(8'h00, 32'hFFF7_FEAF);
    both_chk(16'h0230, "R9 cut kept in input");

    // R11 level word read-only
    wr(8'h10, 32'hFFFF_FFFF);
    both_chk(16'h0230, "R11 level unchanged");
    rd(8'h00, 32'hFFF7_FEAF, "R11 dir unchanged");
    rd(8'h14, 32'h0000_0304, "R11 out unchanged");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule